// File: doc/BRIEF.md
# Coherent Buffered Compare Register

This block keeps a set of wide compare or period values that software updates one bus byte at a time. Each channel has a holding buffer and an active register. Byte writes land in the holding buffer only. The active register, which the comparator downstream uses, is loaded only once every byte of the word has been written. A half-written value therefore never reaches the comparator.

Each channel has its own mode. In output-compare mode the completed word moves to the active register straight away. In PWM mode it waits for the counter's period-end pulse, so the duty or period of a running waveform never changes mid-period. Every PWM channel that is waiting moves on the same period-end edge.

Each channel also has a control-write strobe. It throws away any bytes already collected and restarts the byte sequence. The same structure serves the modulus register: give it a channel whose strobe is driven by writes to the main timer control register.

Top module: `buffered_compare_reg`

## Requirements
- R1: After a clock edge with `rst` high, every active value is 0x0000 and no channel has any byte collected, so a single byte write that follows causes no transfer.
- R2: A channel's active value does not change while fewer than all of its bytes have been written since the last transfer or cancel.
- R3: Bytes may be written in any order. A second write to the same lane before the word is complete replaces the earlier byte.
- R4: In output-compare mode (`pwm_mode[c]` = 0), the completed word appears on the active output one clock after the edge that accepted the last missing byte.
- R5: In PWM mode (`pwm_mode[c]` = 1), a completed word transfers at the first edge where `period_end` is high and the word was already complete before that edge. A `period_end` in the same cycle as the completing byte write does not transfer.
- R6: All PWM channels that hold a completed word update on the same `period_end` edge.
- R7: `ctrl_wr[c]` high at an edge discards all bytes collected for channel c. It wins over a byte write to channel c in the same cycle, which is dropped, and over a transfer due in that cycle, which does not happen.
- R8: A transfer empties the channel's collected bytes, so the next word needs every byte again. A byte write in the transfer cycle counts as the first byte of the new sequence and does not alter the value being transferred.
- R9: Lane 1 carries bits 15:8 and lane 0 carries bits 7:0. Channel c appears on `active_val[c*16 +: 16]`.
- R10: Byte writes, control writes and transfers of one channel leave every other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_ch | input | 1 | Channel addressed by the byte write |
| wr_lane | input | 1 | Byte lane: 1 = high byte, 0 = low byte |
| wr_data | input | 8 | Byte written |
| ctrl_wr | input | 2 | Per-channel control-register write strobe (cancel) |
| pwm_mode | input | 2 | Per-channel mode: 1 = PWM, 0 = output compare |
| period_end | input | 1 | One-cycle pulse at the counter's period boundary |
| active_val | output | 32 | Active values of all channels, channel 0 in the low bits |

## Verification
Directed sequences try high-then-low and low-then-high orders, repeated writes to the same lane, and incomplete words. These separate correct byte merging and lane order from early transfer. PWM cases put `period_end` before, together with, and after the completing byte, which shows whether the transfer waits for a boundary that follows completion. Cancels are placed against a same-cycle byte write and against a due transfer to show the priorities. Seeded random traffic mixes channels, modes, cancels and period pulses, and is compared every cycle with a bench model of the requirements, which also checks that channels stay separate.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic {
        CBR_OC  = 1'b0,
        CBR_PWM = 1'b1
    } cbr_mode_e;

    function automatic logic xfer_ok(cbr_mode_e mode, logic period_end);
        return (mode == CBR_OC) || period_end;
    endfunction

endpackage

// File: rtl/cbr_lane_buf.sv
module cbr_lane_buf #(
    parameter int VAL_W = 16,
    parameter int BUS_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [((VAL_W/BUS_W) > 1 ? $clog2(VAL_W/BUS_W) : 1)-1:0] wr_lane,
    input  logic [BUS_W-1:0]                      wr_data,
    input  logic                                  cancel,
    input  logic                                  consume,
    output logic [VAL_W-1:0]                      held,
    output logic                                  full
);
    localparam int NBYTES = VAL_W / BUS_W;

    logic [NBYTES-1:0][BUS_W-1:0] bytes_q;
    logic [NBYTES-1:0]            have_q;
    logic [NBYTES-1:0]            have_d;

    always_comb begin
        have_d = have_q;
        if (cancel) begin
            have_d = '0;
        end else begin
            if (consume) have_d = '0;
            if (wr_en)   have_d[wr_lane] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            have_q  <= '0;
        end else begin
            have_q <= have_d;
            if (wr_en && !cancel) bytes_q[wr_lane] <= wr_data;
        end
    end

    assign held = bytes_q;
    assign full = &have_q;

    // R7: a cancel leaves nothing collected
    a_r7_cancel_empties: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !full);

    // R8: a transfer without a concurrent write restarts the sequence
    a_r8_consume_restarts: assert property (@(posedge clk) disable iff (rst)
        (consume && !wr_en) |=> !full);

endmodule

// File: rtl/cbr_xfer.sv
module cbr_xfer
    import cbr_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             full,
    input  cbr_mode_e        mode,
    input  logic             period_end,
    input  logic             cancel,
    input  logic [VAL_W-1:0] held,
    output logic             consume,
    output logic [VAL_W-1:0] active
);
    logic [VAL_W-1:0] active_q;

    assign consume = full && !cancel && xfer_ok(mode, period_end);

    always_ff @(posedge clk) begin
        if (rst)          active_q <= '0;
        else if (consume) active_q <= held;
    end

    assign active = active_q;

    // R1: reset clears the active value
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (active_q == '0));

    // R4: output-compare mode loads a complete word on the next edge
    a_r4_oc_loads: assert property (@(posedge clk) disable iff (rst)
        (full && mode == CBR_OC && !cancel) |=> (active_q == $past(held)));

    // R5: PWM mode holds the active value until a period boundary
    a_r5_pwm_waits: assert property (@(posedge clk) disable iff (rst)
        (mode == CBR_PWM && !period_end) |=> $stable(active_q));

    // R2: an incomplete word never moves
    a_r2_partial_holds: assert property (@(posedge clk) disable iff (rst)
        !full |=> $stable(active_q));

endmodule

// File: rtl/buffered_compare_reg.sv
module buffered_compare_reg
    import cbr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int VAL_W  = 16,
    parameter int BUS_W  = 8,
    localparam int NBYTES = VAL_W / BUS_W,
    localparam int LANE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic [LANE_W-1:0]       wr_lane,
    input  logic [BUS_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       ctrl_wr,
    input  logic [NUM_CH-1:0]       pwm_mode,
    input  logic                    period_end,
    output logic [NUM_CH*VAL_W-1:0] active_val
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             hit;
        logic             full;
        logic             consume;
        logic [VAL_W-1:0] held;
        logic [VAL_W-1:0] act;

        assign hit = wr_en && (wr_ch == CH_W'(c));

        cbr_lane_buf #(.VAL_W(VAL_W), .BUS_W(BUS_W)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (hit),
            .wr_lane (wr_lane),
            .wr_data (wr_data),
            .cancel  (ctrl_wr[c]),
            .consume (consume),
            .held    (held),
            .full    (full)
        );

        cbr_xfer #(.VAL_W(VAL_W)) u_xfer (
            .clk        (clk),
            .rst        (rst),
            .full       (full),
            .mode       (cbr_mode_e'(pwm_mode[c])),
            .period_end (period_end),
            .cancel     (ctrl_wr[c]),
            .held       (held),
            .consume    (consume),
            .active     (act)
        );

        assign active_val[c*VAL_W +: VAL_W] = act;
    end

endmodule

// File: tb/sim_buffered_compare_reg.sv
`timescale 1ns/1ps
module sim_buffered_compare_reg;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [0:0]  wr_ch;
    logic [0:0]  wr_lane;
    logic [7:0]  wr_data;
    logic [1:0]  ctrl_wr;
    logic [1:0]  pwm_mode;
    logic        period_end;
    logic [31:0] active_val;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_buf [NCH];
    logic [15:0] m_act [NCH];
    logic [1:0]  m_have[NCH];

    always #2.5 clk = ~clk;

    buffered_compare_reg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_lane(wr_lane),
        .wr_data(wr_data), .ctrl_wr(ctrl_wr), .pwm_mode(pwm_mode),
        .period_end(period_end), .active_val(active_val)
    );

    function automatic logic [15:0] chan(input logic [31:0] v, input int c);
        return v[c*16 +: 16];
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update per the requirements, using the state held before the edge
    task automatic model_edge();
        for (int c = 0; c < NCH; c++) begin
            logic hit, cons;
            hit  = wr_en && (wr_ch == 1'(c));
            cons = (m_have[c] == 2'b11) && !ctrl_wr[c] && (!pwm_mode[c] || period_end);
            if (cons) m_act[c] = m_buf[c];
            if (ctrl_wr[c]) begin
                m_have[c] = 2'b00;
            end else begin
                if (cons) m_have[c] = 2'b00;
                if (hit) begin
                    m_have[c][wr_lane] = 1'b1;
                    if (wr_lane) m_buf[c][15:8] = wr_data;
                    else         m_buf[c][7:0]  = wr_data;
                end
            end
        end
    endtask

    task automatic step(input string tag, input logic we, input logic ch, input logic ln,
                        input logic [7:0] d, input logic [1:0] cw, input logic pe);
        wr_en = we; wr_ch = ch; wr_lane = ln; wr_data = d; ctrl_wr = cw; period_end = pe;
        @(posedge clk);
        model_edge();
        #1;
        for (int c = 0; c < NCH; c++) check({tag, " model R10"}, chan(active_val, c), m_act[c]);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 1'b0, 8'h00, 2'b00, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_ch = 0; wr_lane = 0; wr_data = 0;
        ctrl_wr = 0; pwm_mode = 0; period_end = 0;
        for (int c = 0; c < NCH; c++) begin m_buf[c] = 0; m_act[c] = 0; m_have[c] = 0; end
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 reset ch0", chan(active_val, 0), 16'h0000);
        check("R1 reset ch1", chan(active_val, 1), 16'h0000);

        // R1/R2/R4/R9: output compare, high then low
        pwm_mode = 2'b00;
        step("R1 single byte", 1, 0, 1, 8'hAB, 2'b00, 0);
        idle("R2 partial");
        check("R2 partial held", chan(active_val, 0), 16'h0000);
        step("R4 completing write", 1, 0, 0, 8'hCD, 2'b00, 0);
        check("R4 not before next edge", chan(active_val, 0), 16'h0000);
        idle("R4 load");
        check("R4 R9 loaded", chan(active_val, 0), 16'hABCD);

        // R3: low first, rewritten, then high
        step("R3 lo", 1, 0, 0, 8'h11, 2'b00, 0);
        step("R3 lo again", 1, 0, 0, 8'h22, 2'b00, 0);
        step("R3 hi", 1, 0, 1, 8'h33, 2'b00, 0);
        idle("R3 load");
        check("R3 overwrite order", chan(active_val, 0), 16'h3322);

        // R5: PWM on channel 1
        pwm_mode = 2'b10;
        step("R5 lo", 1, 1, 0, 8'h55, 2'b00, 0);
        step("R5 hi with period_end", 1, 1, 1, 8'h66, 2'b00, 1);
        idle("R5 wait");
        check("R5 no early load", chan(active_val, 1), 16'h0000);
        step("R5 boundary", 0, 0, 0, 8'h00, 2'b00, 1);
        check("R5 loaded at boundary", chan(active_val, 1), 16'h6655);

        // R6: two PWM channels move together
        pwm_mode = 2'b11;
        step("R6 a", 1, 0, 1, 8'h12, 2'b00, 0);
        step("R6 b", 1, 1, 0, 8'h78, 2'b00, 0);
        step("R6 c", 1, 0, 0, 8'h34, 2'b00, 0);
        step("R6 d", 1, 1, 1, 8'h56, 2'b00, 0);
        idle("R6 wait");
        check("R6 ch0 held", chan(active_val, 0), 16'h3322);
        step("R6 boundary", 0, 0, 0, 8'h00, 2'b00, 1);
        check("R6 ch0", chan(active_val, 0), 16'h1234);
        check("R6 ch1", chan(active_val, 1), 16'h5678);

        // R7: cancels
        pwm_mode = 2'b10;
        step("R7 hi", 1, 0, 1, 8'h9A, 2'b00, 0);
        step("R7 cancel", 0, 0, 0, 8'h00, 2'b01, 0);
        step("R7 lo", 1, 0, 0, 8'hBC, 2'b00, 0);
        idle("R7 after");
        check("R7 cancelled partial", chan(active_val, 0), 16'h1234);
        step("R7 cancel with write", 1, 0, 1, 8'h77, 2'b01, 0);
        idle("R7 drop");
        step("R7 lo2", 1, 0, 0, 8'hEE, 2'b00, 0);
        idle("R7 drop2");
        check("R7 same-cycle write dropped", chan(active_val, 0), 16'h1234);
        step("R7 pwm lo", 1, 1, 0, 8'h01, 2'b00, 0);
        step("R7 pwm hi", 1, 1, 1, 8'h02, 2'b00, 0);
        step("R7 cancel at boundary", 0, 0, 0, 8'h00, 2'b10, 1);
        step("R7 boundary after", 0, 0, 0, 8'h00, 2'b00, 1);
        check("R7 transfer cancelled", chan(active_val, 1), 16'h5678);

        // R8: write in the transfer cycle starts a new sequence
        pwm_mode = 2'b00;
        step("R8 fill a", 1, 0, 1, 8'h44, 2'b01, 0);
        step("R8 fill a hi", 1, 0, 1, 8'h44, 2'b00, 0);
        step("R8 fill a lo", 1, 0, 0, 8'h45, 2'b00, 0);
        step("R8 write at transfer", 1, 0, 1, 8'h99, 2'b00, 0);
        check("R8 transferred old", chan(active_val, 0), 16'h4445);
        idle("R8 one byte");
        check("R8 new sequence pending", chan(active_val, 0), 16'h4445);
        step("R8 lo", 1, 0, 0, 8'h98, 2'b00, 0);
        idle("R8 load");
        check("R8 new word", chan(active_val, 0), 16'h9998);

        // Random traffic against the model
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:28] == 0) pwm_mode = r[27:26];
            step("R2 R3 R4 R5 R6 R7 R8 random", r[0] | r[1], r[2], r[3], r[11:4],
                 {(r[15:13] == 0), (r[18:16] == 0)}, (r[21:19] == 0));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule